// File: doc/BRIEF.md
# Pruned 8x8 DCT Token Extractor

This block turns one 8x8 tile of 8-bit pixels into a compact frequency-domain token. The token holds the 14 lowest-frequency two-dimensional DCT coefficients, taken in zig-zag order. Pixels stream in row by row over a valid/ready port. While the tile arrives, a vertical pass folds each pixel into 40 running sums, one for each retained vertical frequency (0..4) and each tile column. Once the tile is complete, the sums are rounded down to 9 bits. A horizontal pass (frequencies 0..3) then produces one coefficient per output beat.

Every product is taken against a fixed cosine constant. Each constant is a bank of shifts and adds, so the block has no general multiplier. The constants lose precision as the frequency rises: 8 bits for the lowest frequency down to 4 bits for the highest frequency kept.

Back-pressure: on the input side, a pixel moves only on a cycle where pix_valid and pix_ready are both high. pix_ready is low for the whole time the 14 coefficients of the previous tile are being drained. On the output side, a beat moves only on a cycle where coef_valid and coef_ready are both high. While a beat is stalled, it holds its data, index and last flag unchanged.

Top module: `freq_token_dct`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, pix_ready is 1 and coef_valid and coef_last are 0.
- R2: The pixel accepted as the n-th of a tile (n = 0..63) is pixel p[n/8][n%8]: row n/8, column n%8. pix_ready is 0 from the cycle after the 64th accepted pixel until the last coefficient is accepted. pix_valid and pix_data have no effect during that time. pix_ready returns to 1 on the cycle after the last coefficient is accepted.
- R3: Each tile yields exactly 14 output beats. coef_idx counts 0 to 13 in order, and coef_last is 1 only on index 13.
- R4: coef_valid rises on the first cycle after the clock edge that accepts the 64th pixel.
- R5: The constant for frequency f and sample s is c(f,s) = round(128·a_f·cos((2s+1)fπ/16)), with a_0 = sqrt(1/8) and a_f = 1/2 for f > 0. Trimmed to b bits, it becomes floor(c/2^(8-b))·2^(8-b). The vertical pass uses b = 8-u for frequency u. The horizontal pass uses b = 8-floor(4v/3) for frequency v, which gives 8, 7, 6, 4.
- R6: The vertical sums are T[u][j] = Σ_i c_u,i·(p[i][j]-128), using the vertical-pass trimmed constants of R5. Each sum is rounded to R[u][j] = clamp(floor((T+64)/128), -256, 255): halves round upward, and the result saturates to 9-bit signed.
- R7: The coefficient at vertical frequency u and horizontal frequency v is Y = Σ_j R[u][j]·c_v,j, using the horizontal-pass trimmed constants of R5. It is output as a 20-bit two's-complement value in coef_data.
- R8: Index k carries (u,v) in this order: (0,0),(0,1),(1,0),(2,0),(1,1),(0,2),(0,3),(1,2),(2,1),(3,0),(4,0),(3,1),(2,2),(1,3). The 5x4 entries not in this list, (4,3) among them, are never output.
- R9: While coef_valid is 1 and coef_ready is 0, coef_valid, coef_data, coef_idx and coef_last hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel beat present |
| pix_ready | output | 1 | Block can take a pixel |
| pix_data | input | 8 | Unsigned pixel, row-major within the tile |
| coef_valid | output | 1 | Coefficient beat present |
| coef_ready | input | 1 | Consumer takes the coefficient |
| coef_data | output | 20 | Signed coefficient |
| coef_idx | output | 4 | Zig-zag position 0..13 |
| coef_last | output | 1 | Final beat of the token |

## Verification
The bench sends flat black and flat white tiles. These drive the 9-bit rounding into both saturation limits, so a design that wraps instead of clamping gives a DC term with the wrong sign. A checkerboard and stripe tiles load the highest frequencies kept, where the coarsest constants and their floor trimming act. Here a zig-zag entry taken in the wrong order, or a transposed constant, gives wrong values at specific indices. Random tiles with random input gaps and output stalls test whether data holds under back-pressure and whether the accumulators start fresh on each tile. Pixels offered while the block is draining check that none are taken, since a taken pixel would corrupt the next token.

// File: rtl/tokdct_pkg.sv
package tokdct_pkg;
  localparam int TILE  = 8;   // DCT length
  localparam int CBITS = 8;   // constant width, 7 fractional bits
  localparam int CMIN  = 4;   // width of the coarsest constant kept

  // 64*cos(m*pi/16), rounded
  function automatic int cos_mag(input int m);
    case (m)
      0: return 64;  1: return 63;  2: return 59;  3: return 53;
      4: return 45;  5: return 36;  6: return 24;  7: return 12;
      default: return 0;
    endcase
  endfunction

  // full-precision basis value for frequency f, sample s
  function automatic int basis(input int f, input int s);
    int a;
    int sg;
    if (f == 0) return 45;
    a  = ((2 * s + 1) * f) % 32;
    sg = 1;
    if (a > 16) a = 32 - a;
    if (a > 8) begin
      a  = 16 - a;
      sg = -1;
    end
    return sg * cos_mag(a);
  endfunction

  // constant width for frequency idx out of n retained
  function automatic int prec(input int idx, input int n);
    return CBITS - ((CBITS - CMIN) * idx) / (n - 1);
  endfunction

  // basis value with its low bits floored away
  function automatic int qcoef(input int f, input int s, input int bits);
    int sh;
    sh = CBITS - bits;
    return (basis(f, s) >>> sh) <<< sh;
  endfunction

  // zig-zag walk of the kept corner: vertical then horizontal frequency
  function automatic int zz_row(input int k);
    case (k)
      2, 7, 13:  return 1;
      3, 8, 12:  return 2;
      9, 11:     return 3;
      10:        return 4;
      4:         return 1;
      default:   return 0;
    endcase
  endfunction

  function automatic int zz_col(input int k);
    case (k)
      1, 4, 8, 11: return 1;
      5, 7, 12:    return 2;
      6, 13:       return 3;
      default:     return 0;
    endcase
  endfunction
endpackage

// File: rtl/tokdct_cmul.sv
module tokdct_cmul import tokdct_pkg::*; #(
  parameter int IW = 9,
  parameter int OW = 19,
  parameter int K  = 0
) (
  input  logic signed [IW-1:0] x,
  output logic signed [OW-1:0] y
);
  localparam int MAG = (K < 0) ? -K : K;

  logic signed [OW-1:0] xe;
  logic signed [OW-1:0] sum;

  assign xe = OW'(x);

  always_comb begin
    sum = '0;
    for (int b = 0; b < CBITS; b++)
      if (MAG[b]) sum = sum + (xe <<< b);
    y = (K < 0) ? -sum : sum;
  end
endmodule

// File: rtl/tokdct_rows.sv
module tokdct_rows import tokdct_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 5,
  parameter int TW    = 19,
  localparam int IW   = PIX_W + 1,
  localparam int AW   = $clog2(TILE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PIX_W-1:0]     pix,
  input  logic [AW-1:0]        row_i,
  input  logic [AW-1:0]        col_j,
  output logic signed [TW-1:0] acc [ROWS][TILE]
);
  logic signed [IW-1:0] xs;
  logic signed [TW-1:0] prod [ROWS][TILE];
  logic signed [TW-1:0] pick [ROWS];

  // level shift by half range: invert MSB, then sign extend
  assign xs = {{2{~pix[PIX_W-1]}}, pix[PIX_W-2:0]};

  for (genvar u = 0; u < ROWS; u++) begin : g_freq
    for (genvar i = 0; i < TILE; i++) begin : g_samp
      tokdct_cmul #(.IW(IW), .OW(TW), .K(qcoef(u, i, prec(u, ROWS)))) u_mul (
        .x(xs), .y(prod[u][i]));
    end
    assign pick[u] = prod[u][row_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '{default: '0};
    end else if (en) begin
      for (int u = 0; u < ROWS; u++)
        acc[u][col_j] <= (row_i == '0) ? pick[u] : acc[u][col_j] + pick[u];
    end
  end
endmodule

// File: rtl/tokdct_cols.sv
module tokdct_cols import tokdct_pkg::*; #(
  parameter int ROWS     = 5,
  parameter int COLS     = 4,
  parameter int TW       = 19,
  parameter int MID_W    = 9,
  parameter int RQ_SHIFT = 7,
  parameter int YW       = 20,
  localparam int UW      = $clog2(ROWS),
  localparam int VW      = $clog2(COLS)
) (
  input  logic signed [TW-1:0] acc [ROWS][TILE],
  input  logic [UW-1:0]        u_sel,
  input  logic [VW-1:0]        v_sel,
  output logic signed [YW-1:0] y
);
  localparam int MAXV = (1 << (MID_W - 1)) - 1;
  localparam int MINV = -(1 << (MID_W - 1));

  logic signed [TW:0]      rnd [TILE];
  logic signed [MID_W-1:0] q   [TILE];
  logic signed [YW-1:0]    cp  [COLS][TILE];
  logic signed [YW-1:0]    sum;

  // round half up, then clamp to the mid precision
  always_comb begin
    for (int j = 0; j < TILE; j++) begin
      rnd[j] = ((TW+1)'(acc[u_sel][j]) + (TW+1)'(1 <<< (RQ_SHIFT - 1))) >>> RQ_SHIFT;
      if (rnd[j] > (TW+1)'(MAXV))      q[j] = MID_W'(MAXV);
      else if (rnd[j] < (TW+1)'(MINV)) q[j] = MID_W'(MINV);
      else                             q[j] = rnd[j][MID_W-1:0];
    end
  end

  for (genvar v = 0; v < COLS; v++) begin : g_freq
    for (genvar j = 0; j < TILE; j++) begin : g_samp
      tokdct_cmul #(.IW(MID_W), .OW(YW), .K(qcoef(v, j, prec(v, COLS)))) u_mul (
        .x(q[j]), .y(cp[v][j]));
    end
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < TILE; j++) sum = sum + cp[v_sel][j];
    y = sum;
  end
endmodule

// File: rtl/freq_token_dct.sv
module freq_token_dct import tokdct_pkg::*; #(
  parameter int PIX_W    = 8,
  parameter int ROWS     = 5,
  parameter int COLS     = 4,
  parameter int KEEP     = 14,
  parameter int MID_W    = 9,
  parameter int RQ_SHIFT = 7,
  localparam int YW      = MID_W + CBITS + 3,
  localparam int IDX_W   = $clog2(KEEP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [PIX_W-1:0]     pix_data,
  output logic                 coef_valid,
  input  logic                 coef_ready,
  output logic signed [YW-1:0] coef_data,
  output logic [IDX_W-1:0]     coef_idx,
  output logic                 coef_last
);
  localparam int TW   = PIX_W + CBITS + 3;
  localparam int NPIX = TILE * TILE;
  localparam int PCW  = $clog2(NPIX);
  localparam int AW   = $clog2(TILE);
  localparam int UW   = $clog2(ROWS);
  localparam int VW   = $clog2(COLS);

  logic                 draining;
  logic [PCW-1:0]       pcnt;
  logic [IDX_W-1:0]     k;
  logic                 take;
  logic [UW-1:0]        u_sel;
  logic [VW-1:0]        v_sel;
  logic signed [TW-1:0] acc [ROWS][TILE];

  assign pix_ready = !draining;
  assign take      = pix_valid && pix_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining <= 1'b0;
      pcnt     <= '0;
      k        <= '0;
    end else if (!draining) begin
      if (take) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PCW'(NPIX - 1)) begin
          draining <= 1'b1;
          k        <= '0;
        end
      end
    end else if (coef_ready) begin
      if (k == IDX_W'(KEEP - 1)) draining <= 1'b0;
      else                       k <= k + 1'b1;
    end
  end

  tokdct_rows #(.PIX_W(PIX_W), .ROWS(ROWS), .TW(TW)) u_rows (
    .clk(clk), .rst_n(rst_n), .en(take), .pix(pix_data),
    .row_i(pcnt[PCW-1:AW]), .col_j(pcnt[AW-1:0]), .acc(acc));

  always_comb begin
    u_sel = UW'(zz_row(int'(k)));
    v_sel = VW'(zz_col(int'(k)));
  end

  tokdct_cols #(.ROWS(ROWS), .COLS(COLS), .TW(TW), .MID_W(MID_W),
                .RQ_SHIFT(RQ_SHIFT), .YW(YW)) u_cols (
    .acc(acc), .u_sel(u_sel), .v_sel(v_sel), .y(coef_data));

  assign coef_valid = draining;
  assign coef_idx   = k;
  assign coef_last  = draining && (k == IDX_W'(KEEP - 1));
endmodule

// File: rtl/freq_token_dct_chk.sv
module freq_token_dct_chk import tokdct_pkg::*; #(
  parameter int KEEP  = 14,
  parameter int YW    = 20,
  parameter int IDX_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_valid,
  input logic                 pix_ready,
  input logic                 coef_valid,
  input logic                 coef_ready,
  input logic signed [YW-1:0] coef_data,
  input logic [IDX_W-1:0]     coef_idx,
  input logic                 coef_last
);
  localparam int HW = $clog2(TILE * TILE);
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else if (pix_valid && pix_ready) hcnt <= hcnt + 1'b1;
  end

  a_r2_ready_low_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid |-> !pix_ready);

  a_r2_resume_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready && coef_last) |=> (!coef_valid && pix_ready));

  a_r3_first_index: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coef_valid) |-> (coef_idx == '0));

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready && !coef_last) |=>
      (coef_valid && coef_idx == $past(coef_idx) + 1'b1));

  a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid |-> (coef_idx <= IDX_W'(KEEP - 1)));

  a_r4_drain_follows_tile: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && hcnt == '1) |=> coef_valid);

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !coef_ready) |=>
      (coef_valid && $stable(coef_data) && $stable(coef_idx) && $stable(coef_last)));
endmodule

bind freq_token_dct freq_token_dct_chk #(.KEEP(KEEP), .YW(YW), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_freq_token_dct.sv
`timescale 1ns/1ps
module tb_freq_token_dct;
  localparam int KEEP = 14;
  localparam int YW   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic pix_ready;
  logic [7:0] pix_data = '0;
  logic coef_valid;
  logic coef_ready = 1'b0;
  logic signed [YW-1:0] coef_data;
  logic [3:0] coef_idx;
  logic coef_last;

  int checks = 0;
  int fails = 0;
  int tile [64];
  longint expv [KEEP];
  // R8 zig-zag map
  int zr [KEEP] = '{0,0,1,2,1,0,0,1,2,3,4,3,2,1};
  int zc [KEEP] = '{0,1,0,0,1,2,3,2,1,0,0,1,2,3};

  always #2 clk = ~clk;

  freq_token_dct dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5 constants from the cosine definition
  function automatic int qc(input int f, input int s, input int bits);
    real a;
    real r;
    int c;
    a = (f == 0) ? $sqrt(0.125) : 0.5;
    r = a * $cos(real'((2 * s + 1) * f) * 3.141592653589793 / 16.0) * 128.0;
    c = (r >= 0.0) ? int'($floor(r + 0.5)) : -int'($floor(-r + 0.5));
    return (c >>> (8 - bits)) <<< (8 - bits);
  endfunction

  task automatic build_expect();
    int r [5][8];
    for (int u = 0; u < 5; u++)
      for (int j = 0; j < 8; j++) begin
        int t;
        t = 0;
        for (int i = 0; i < 8; i++) t += qc(u, i, 8 - u) * (tile[i*8+j] - 128);
        t = (t + 64) >>> 7;          // R6 round half up
        if (t > 255) t = 255;
        if (t < -256) t = -256;
        r[u][j] = t;
      end
    for (int k = 0; k < KEEP; k++) begin
      longint s;
      s = 0;
      for (int j = 0; j < 8; j++)
        s += longint'(r[zr[k]][j] * qc(zc[k], j, 8 - (4 * zc[k]) / 3));  // R7
      expv[k] = s;
    end
  endtask

  // entered and left at a falling edge
  task automatic run_tile(input int gap_pct, input int stall_pct, input bit junk);
    build_expect();
    for (int n = 0; n < 64; n++) begin
      while (int'($urandom_range(0, 99)) < gap_pct) begin
        pix_valid = 1'b0;
        pix_data  = 8'($urandom);
        @(negedge clk);
      end
      chk(pix_ready, "R2 ready while loading", longint'(pix_ready), 1);
      pix_valid = 1'b1;
      pix_data  = 8'(tile[n]);
      @(negedge clk);
    end
    pix_valid = junk;
    pix_data  = 8'($urandom);
    chk(coef_valid, "R4 valid after 64th pixel", longint'(coef_valid), 1);
    for (int k = 0; k < KEEP; k++) begin
      while (int'($urandom_range(0, 99)) < stall_pct) begin
        logic signed [YW-1:0] d;
        logic [3:0] ix;
        logic lf;
        coef_ready = 1'b0;
        d = coef_data; ix = coef_idx; lf = coef_last;
        @(negedge clk);
        pix_data = 8'($urandom);
        chk(coef_valid && coef_data == d && coef_idx == ix && coef_last == lf,
            "R9 hold under stall", longint'(coef_data), longint'(d));
      end
      coef_ready = 1'b1;
      chk(!pix_ready, "R2 ready low while draining", longint'(pix_ready), 0);
      chk(coef_valid, "R3 valid per beat", longint'(coef_valid), 1);
      chk(coef_idx == 4'(k), "R3 index order", longint'(coef_idx), k);
      chk(coef_last == (k == KEEP - 1), "R3 last flag", longint'(coef_last),
          longint'(k == KEEP - 1));
      chk(longint'(coef_data) == expv[k], $sformatf("R5 R6 R7 R8 coef k=%0d", k),
          longint'(coef_data), expv[k]);
      @(negedge clk);
    end
    coef_ready = 1'b0;
    pix_valid  = 1'b0;
    chk(!coef_valid, "R3 exactly 14 beats", longint'(coef_valid), 0);
    chk(pix_ready, "R2 ready back after last", longint'(pix_ready), 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0DC7));
    repeat (3) @(negedge clk);
    chk(pix_ready && !coef_valid && !coef_last, "R1 reset state",
        longint'({pix_ready, coef_valid, coef_last}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_ready && !coef_valid && !coef_last, "R1 after release",
        longint'({pix_ready, coef_valid, coef_last}), 4);

    foreach (tile[n]) tile[n] = 0;           // negative saturation
    run_tile(0, 0, 1'b0);
    foreach (tile[n]) tile[n] = 255;         // positive saturation
    run_tile(0, 30, 1'b1);
    foreach (tile[n]) tile[n] = (((n / 8) + (n % 8)) % 2 == 1) ? 255 : 0;
    run_tile(10, 0, 1'b1);
    foreach (tile[n]) tile[n] = (n % 8) * 36;
    run_tile(0, 0, 1'b0);
    foreach (tile[n]) tile[n] = ((n / 8) % 2 == 1) ? 200 : 40;
    run_tile(20, 20, 1'b1);
    foreach (tile[n]) tile[n] = (n == 9) ? 192 : 128;
    run_tile(0, 0, 1'b0);
    for (int t = 0; t < 40; t++) begin
      foreach (tile[n]) tile[n] = int'($urandom_range(0, 255));
      run_tile((t % 3) * 15, (t % 4) * 12, t[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule